// File: doc/BRIEF.md
# Parity-Protected Control Register Checker

This block holds a set of processor state registers: an integer group, a floating-point group, the program counter pair, a status word, trap base and trap level, an interrupt level, five register-window counters and a trap type register. Every register except trap type stores one even-parity bit. The block decides when a stored mismatch becomes a reported error. It also decides which event clears that error.

Each register follows its own detection rule. Some are checked continuously, some only when an instruction reads them, some only under a status-mode bit. Each register also has its own clearing rule: a full write, a hardware trap acknowledge, or either one. Error flags are sticky. When several flags are set, the highest-priority class drives a 3-bit class output. A class of fatal also raises a request for the fatal error state. A test-only inject port flips one register's stored parity bit, so that every detection and clearing path can be exercised.

Register index map: integer 0..3, floating point 4..7, program counter 8, next program counter 9, status 10, trap base 11, trap level 12, interrupt level 13, window counters 14..18, trap type 19. Status bit 0 is the reset/error-mode bit and status bit 1 is the interrupt-enable bit.

Top module: `pcr_checker`

## Requirements
- R1: After reset, all stored data and parity are zero, `err_valid_o` = 0, `err_class_o` = 0 and `fatal_req_o` = 0.
- R2: Integer registers (class 2) and floating-point registers (class 1) flag a parity mismatch only on the clock edge where `rd_en_i` selects them. Without a read, no error appears.
- R3: A full write (`wr_mask_i` all ones) to an integer or floating-point register regenerates its parity and clears its flag. A partial write changes only the masked bits and updates parity only by those bits' change. It therefore neither clears an existing fault nor creates a new one.
- R4: Program counter, next program counter and status are checked on every edge with class 3. A full write does not clear their flag. `trap_ack_i` clears it and regenerates their parity.
- R5: Trap base and trap level set a fatal flag (class 4, `fatal_req_o` = 1) on a mismatch, but only while status bit 0 is 0.
- R6: A fatal flag is cleared only by a full write to its register. `trap_ack_i` leaves it set.
- R7: The interrupt level register is checked on every edge while status bit 1 is 1, and otherwise only on a read. It reports class 3, and a full write clears it.
- R8: The window counters are checked on every edge with class 3. Either a full write to the counter or `trap_ack_i` clears the flag.
- R9: The trap type register never reports an error, whether it is injected, read or written.
- R10: `err_valid_o` is 1 exactly when any flag is set. `err_class_o` shows the highest pending class in the order 4 > 3 > 2 > 1.
- R11: A set flag stays set until its own clearing event. `inj_en_i` inverts the addressed register's stored parity bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 5 | Write register index |
| wr_data_i | input | 16 | Write data |
| wr_mask_i | input | 16 | Bit write mask; all ones means a full write |
| rd_en_i | input | 1 | Instruction read access strobe |
| rd_idx_i | input | 5 | Read register index |
| rd_data_o | output | 16 | Stored value of the register selected by `rd_idx_i` |
| trap_ack_i | input | 1 | Hardware trap sequence rewrite acknowledge |
| inj_en_i | input | 1 | Test-only parity flip strobe |
| inj_idx_i | input | 5 | Index of the register whose parity is flipped |
| err_valid_o | output | 1 | Any error flag pending |
| err_class_o | output | 3 | Highest pending error class |
| fatal_req_o | output | 1 | Fatal error-state request |

## Verification
An injected parity flip lands at one edge. A continuously checked register then shows its error one edge later, so the result appears two edges after the inject strobe is sampled. An access-checked register shows its error one edge after the read strobe. Full writes and trap acknowledges clear a flag at the same edge that samples them, and `rd_data_o` follows a write after that single edge. The bench drives inputs one time unit after a rising edge, advances whole cycles, and samples the outputs after the edge at which each result is due. The absence of an error is rechecked after extra idle cycles.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic [2:0] {
    CLS_NONE = 3'd0, CLS_FP = 3'd1, CLS_INT = 3'd2, CLS_STAT = 3'd3, CLS_FATAL = 3'd4
  } err_cls_e;

  typedef enum logic [2:0] {
    DET_NONE, DET_ACCESS, DET_ALWAYS, DET_NOT_RED, DET_IE_OR_ACC
  } det_e;

  typedef struct packed {
    det_e     det;
    logic     clr_wr;
    logic     clr_trap;
    err_cls_e cls;
  } policy_t;

  localparam int NUM_FIXED = 12;
  localparam int OFF_PC    = 0;
  localparam int OFF_NPC   = 1;
  localparam int OFF_STAT  = 2;
  localparam int OFF_TBA   = 3;
  localparam int OFF_TLV   = 4;
  localparam int OFF_ILV   = 5;
  localparam int OFF_WIN   = 6;
  localparam int OFF_TT    = 11;

  function automatic policy_t reg_policy(int idx, int n_int, int n_fp);
    int rel;
    policy_t p;
    rel = idx - n_int - n_fp;
    p = '{det: DET_NONE, clr_wr: 1'b0, clr_trap: 1'b0, cls: CLS_NONE};
    if (idx < n_int)
      p = '{det: DET_ACCESS, clr_wr: 1'b1, clr_trap: 1'b0, cls: CLS_INT};
    else if (idx < n_int + n_fp)
      p = '{det: DET_ACCESS, clr_wr: 1'b1, clr_trap: 1'b0, cls: CLS_FP};
    else if (rel <= OFF_STAT)
      p = '{det: DET_ALWAYS, clr_wr: 1'b0, clr_trap: 1'b1, cls: CLS_STAT};
    else if (rel <= OFF_TLV)
      p = '{det: DET_NOT_RED, clr_wr: 1'b1, clr_trap: 1'b0, cls: CLS_FATAL};
    else if (rel == OFF_ILV)
      p = '{det: DET_IE_OR_ACC, clr_wr: 1'b1, clr_trap: 1'b0, cls: CLS_STAT};
    else if (rel < OFF_TT)
      p = '{det: DET_ALWAYS, clr_wr: 1'b1, clr_trap: 1'b1, cls: CLS_STAT};
    return p;
  endfunction
endpackage

// File: rtl/pcr_reg_store.sv
module pcr_reg_store
  import pcr_pkg::*;
#(
  parameter int N_INT = 4,
  parameter int N_FP  = 4,
  parameter int DW    = 16,
  parameter int NREG  = N_INT + N_FP + NUM_FIXED,
  parameter int IW    = $clog2(NREG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IW-1:0]             wr_idx_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic [DW-1:0]             wr_mask_i,
  input  logic                      trap_ack_i,
  input  logic                      inj_en_i,
  input  logic [IW-1:0]             inj_idx_i,
  output logic [NREG-1:0][DW-1:0]   data_o,
  output logic [NREG-1:0]           mism_o,
  output logic [NREG-1:0]           full_wr_o
);
  logic full_mask;
  assign full_mask = &wr_mask_i;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam policy_t P = reg_policy(g, N_INT, N_FP);
    logic [DW-1:0] d_q, d_nxt;
    logic          p_q, p_nxt, sel;

    assign sel = wr_en_i && (wr_idx_i == IW'(g));

    always_comb begin
      d_nxt = d_q;
      p_nxt = p_q;
      if (sel) begin
        d_nxt = (d_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
        // partial write: adjust parity by the flipped bits only
        p_nxt = full_mask ? ^wr_data_i : p_q ^ (^((d_q ^ wr_data_i) & wr_mask_i));
      end
      if (trap_ack_i && P.clr_trap) p_nxt = ^d_nxt;
      if (inj_en_i && (inj_idx_i == IW'(g))) p_nxt = ~p_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        p_q <= 1'b0;
      end else begin
        d_q <= d_nxt;
        p_q <= p_nxt;
      end
    end

    assign data_o[g]    = d_q;
    assign mism_o[g]    = p_q ^ (^d_q);
    assign full_wr_o[g] = sel && full_mask;
  end
endmodule

// File: rtl/pcr_err_track.sv
module pcr_err_track
  import pcr_pkg::*;
#(
  parameter int N_INT = 4,
  parameter int N_FP  = 4,
  parameter int NREG  = N_INT + N_FP + NUM_FIXED,
  parameter int IW    = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] mism_i,
  input  logic [NREG-1:0] full_wr_i,
  input  logic            rd_en_i,
  input  logic [IW-1:0]   rd_idx_i,
  input  logic            trap_ack_i,
  input  logic            red_i,
  input  logic            ie_i,
  output logic [NREG-1:0] flags_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_flag
    localparam policy_t P = reg_policy(g, N_INT, N_FP);
    logic acc, det, clr, f_q;

    assign acc = rd_en_i && (rd_idx_i == IW'(g));

    always_comb begin
      unique case (P.det)
        DET_ACCESS:    det = acc;
        DET_ALWAYS:    det = 1'b1;
        DET_NOT_RED:   det = !red_i;
        DET_IE_OR_ACC: det = ie_i || acc;
        default:       det = 1'b0;
      endcase
    end

    assign clr = (P.clr_wr && full_wr_i[g]) || (P.clr_trap && trap_ack_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  f_q <= 1'b0;
      else if (clr) f_q <= 1'b0;
      else          f_q <= f_q | (det && mism_i[g]);
    end

    assign flags_o[g] = f_q;
  end
endmodule

// File: rtl/pcr_err_prio.sv
module pcr_err_prio
  import pcr_pkg::*;
#(
  parameter int N_INT = 4,
  parameter int N_FP  = 4,
  parameter int NREG  = N_INT + N_FP + NUM_FIXED
) (
  input  logic [NREG-1:0] flags_i,
  output logic            valid_o,
  output logic [2:0]      cls_o,
  output logic            fatal_o
);
  localparam int NCLS = 5;

  function automatic logic [NREG-1:0] cls_mask(int c);
    logic [NREG-1:0] m;
    m = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(reg_policy(i, N_INT, N_FP).cls) == c) m[i] = 1'b1;
    return m;
  endfunction

  logic [NCLS-1:1] pres;
  for (genvar c = 1; c < NCLS; c++) begin : g_cls
    localparam logic [NREG-1:0] M = cls_mask(c);
    assign pres[c] = |(flags_i & M);
  end

  always_comb begin
    cls_o = CLS_NONE;
    for (int c = 1; c < NCLS; c++)
      if (pres[c]) cls_o = 3'(c);
  end

  assign valid_o = |pres;
  assign fatal_o = pres[CLS_FATAL];
endmodule

// File: rtl/pcr_checker.sv
module pcr_checker
  import pcr_pkg::*;
#(
  parameter int N_INT   = 4,
  parameter int N_FP    = 4,
  parameter int DW      = 16,
  parameter int RED_BIT = 0,
  parameter int IE_BIT  = 1,
  localparam int NREG   = N_INT + N_FP + NUM_FIXED,
  localparam int IW     = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] wr_mask_i,
  input  logic          rd_en_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          trap_ack_i,
  input  logic          inj_en_i,
  input  logic [IW-1:0] inj_idx_i,
  output logic          err_valid_o,
  output logic [2:0]    err_class_o,
  output logic          fatal_req_o
);
  localparam int STAT_IDX = N_INT + N_FP + OFF_STAT;

  logic [NREG-1:0][DW-1:0] data;
  logic [NREG-1:0]         mism, full_wr, err_flags;

  pcr_reg_store #(.N_INT(N_INT), .N_FP(N_FP), .DW(DW), .NREG(NREG), .IW(IW)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .wr_mask_i,
    .trap_ack_i, .inj_en_i, .inj_idx_i,
    .data_o(data), .mism_o(mism), .full_wr_o(full_wr)
  );

  pcr_err_track #(.N_INT(N_INT), .N_FP(N_FP), .NREG(NREG), .IW(IW)) u_track (
    .clk_i, .rst_ni, .mism_i(mism), .full_wr_i(full_wr),
    .rd_en_i, .rd_idx_i, .trap_ack_i,
    .red_i(data[STAT_IDX][RED_BIT]), .ie_i(data[STAT_IDX][IE_BIT]),
    .flags_o(err_flags)
  );

  pcr_err_prio #(.N_INT(N_INT), .N_FP(N_FP), .NREG(NREG)) u_prio (
    .flags_i(err_flags), .valid_o(err_valid_o), .cls_o(err_class_o), .fatal_o(fatal_req_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_idx_i == IW'(i)) rd_data_o = data[i];
  end
endmodule

// File: rtl/pcr_checker_sva.sv
module pcr_checker_sva #(
  parameter int NREG   = 20,
  parameter int DW     = 16,
  parameter int IW     = 5,
  parameter int PC_IDX = 8,
  parameter int TT_IDX = 19
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [DW-1:0]   wr_mask_i,
  input logic            trap_ack_i,
  input logic            err_valid_o,
  input logic [2:0]      err_class_o,
  input logic            fatal_req_o,
  input logic [NREG-1:0] err_flags_i
);
  a_r10_valid_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o == (err_class_o != 3'd0));

  a_r5_fatal_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_req_o |-> (err_class_o == 3'd4) && err_valid_o);

  a_r9_tt_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_flags_i[TT_IDX]);

  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o && !(wr_en_i && (&wr_mask_i)) && !trap_ack_i |=> err_valid_o);

  a_r6_trap_keeps_fatal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_req_o && trap_ack_i && !wr_en_i |=> fatal_req_o);

  a_r4_pc_needs_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flags_i[PC_IDX] && !trap_ack_i |=> err_flags_i[PC_IDX]);
endmodule

bind pcr_checker pcr_checker_sva #(
  .NREG(NREG), .DW(DW), .IW(IW),
  .PC_IDX(N_INT + N_FP + pcr_pkg::OFF_PC), .TT_IDX(N_INT + N_FP + pcr_pkg::OFF_TT)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_mask_i(wr_mask_i),
  .trap_ack_i(trap_ack_i), .err_valid_o(err_valid_o), .err_class_o(err_class_o),
  .fatal_req_o(fatal_req_o), .err_flags_i(err_flags)
);

// File: tb/pcr_checker_tb_top.sv
`timescale 1ns/1ps
module pcr_checker_tb_top;
  localparam int DW = 16;
  localparam int IW = 5;
  localparam int PC = 8, STAT = 10, TBA = 11, TLV = 12, ILV = 13, WIN0 = 14, TT = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en, rd_en, trap_ack, inj_en;
  logic [IW-1:0] wr_idx, rd_idx, inj_idx;
  logic [DW-1:0] wr_data, wr_mask, rd_data;
  logic err_valid, fatal_req;
  logic [2:0] err_class;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pcr_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .wr_mask_i(wr_mask), .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .trap_ack_i(trap_ack), .inj_en_i(inj_en), .inj_idx_i(inj_idx),
    .err_valid_o(err_valid), .err_class_o(err_class), .fatal_req_o(fatal_req)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_err(string tag, int v, int c, int f);
    chk({tag, " valid"}, int'(err_valid), v);
    chk({tag, " class"}, int'(err_class), c);
    chk({tag, " fatal"}, int'(fatal_req), f);
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; trap_ack = 0; inj_en = 0;
    wr_idx = '0; rd_idx = '0; inj_idx = '0; wr_data = '0; wr_mask = '0;
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    step(2);
    rst_n = 1;
    step();
  endtask

  task automatic wr(int idx, int data, int mask);
    wr_en = 1; wr_idx = IW'(idx); wr_data = DW'(data); wr_mask = DW'(mask);
    step();
    wr_en = 0;
  endtask

  task automatic inject(int idx);
    inj_en = 1; inj_idx = IW'(idx); step(); inj_en = 0;
  endtask

  task automatic rd(int idx);
    rd_en = 1; rd_idx = IW'(idx); step(); rd_en = 0;
  endtask

  task automatic trap();
    trap_ack = 1; step(); trap_ack = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_err("R1 reset", 0, 0, 0);
    rd_idx = IW'(STAT);
    #1 chk("R1 status data", int'(rd_data), 0);
  endtask

  task automatic t_int_fp();
    do_reset();
    inject(1); step(3);
    chk_err("R2 int no access", 0, 0, 0);
    rd(1);
    chk_err("R2 int access", 1, 2, 0);
    wr(1, 16'h00f0, 16'hffff);
    chk_err("R3 int full write clears", 0, 0, 0);
    rd(1);
    chk_err("R3 int stays clean", 0, 0, 0);
    inject(5); rd(5);
    chk_err("R2 fp class", 1, 1, 0);
    inject(2); rd(2);
    chk_err("R10 int over fp", 1, 2, 0);
  endtask

  task automatic t_partial();
    do_reset();
    inject(3);
    wr(3, 16'h0a5b, 16'h00ff);
    rd_idx = IW'(3);
    #1 chk("R3 partial data", int'(rd_data), 16'h005b);
    rd(3);
    chk_err("R3 partial keeps fault", 1, 2, 0);
    wr(3, 16'h1300, 16'hff00);
    step();
    chk_err("R3 partial no clear", 1, 2, 0);
    wr(3, 0, 16'hffff);
    wr(0, 16'h0007, 16'h000f);
    rd(0);
    chk_err("R3 partial on clean reg", 0, 0, 0);
  endtask

  task automatic t_core();
    do_reset();
    inject(PC); step();
    chk_err("R4 pc continuous", 1, 3, 0);
    wr(PC, 16'h1234, 16'hffff); step();
    chk_err("R4 pc write no clear", 1, 3, 0);
    trap();
    chk_err("R4 trap clears", 0, 0, 0);
    inject(STAT); step(); trap(); step(2);
    chk_err("R4 trap regenerates status parity", 0, 0, 0);
  endtask

  task automatic t_fatal();
    do_reset();
    inject(TBA); step();
    chk_err("R5 tba fatal", 1, 4, 1);
    trap();
    chk_err("R6 trap keeps fatal", 1, 4, 1);
    wr(TBA, 16'h4000, 16'hffff);
    chk_err("R6 full write clears fatal", 0, 0, 0);
    wr(STAT, 1, 16'hffff);
    inject(TLV); step(3);
    chk_err("R5 gated by mode bit", 0, 0, 0);
    wr(STAT, 0, 16'hffff); step();
    chk_err("R5 ungated tlv", 1, 4, 1);
    wr(TLV, 0, 16'hffff);
    chk_err("R6 tlv clear", 0, 0, 0);
  endtask

  task automatic t_ilv();
    do_reset();
    inject(ILV); step(3);
    chk_err("R7 ie off no check", 0, 0, 0);
    rd(ILV);
    chk_err("R7 access detect", 1, 3, 0);
    wr(ILV, 16'h000f, 16'hffff);
    chk_err("R7 write clears", 0, 0, 0);
    inject(ILV);
    wr(STAT, 2, 16'hffff); step();
    chk_err("R7 ie on detect", 1, 3, 0);
  endtask

  task automatic t_window();
    do_reset();
    inject(WIN0 + 2); step();
    chk_err("R8 window continuous", 1, 3, 0);
    wr(WIN0 + 2, 5, 16'hffff);
    chk_err("R8 write clears", 0, 0, 0);
    inject(WIN0 + 3); step();
    chk_err("R8 second detect", 1, 3, 0);
    trap(); step(2);
    chk_err("R8 trap clears", 0, 0, 0);
  endtask

  task automatic t_tt();
    do_reset();
    inject(TT); rd(TT); step(2);
    chk_err("R9 tt silent", 0, 0, 0);
    wr(TT, 16'h0055, 16'h00f0); rd(TT);
    chk_err("R9 tt after write", 0, 0, 0);
  endtask

  task automatic t_prio();
    do_reset();
    inject(0); rd(0);
    chk_err("R10 int only", 1, 2, 0);
    inject(WIN0); step();
    chk_err("R10 status over int", 1, 3, 0);
    inject(TBA); step();
    chk_err("R10 fatal first", 1, 4, 1);
    step(4);
    chk_err("R11 sticky idle", 1, 4, 1);
    wr(TBA, 0, 16'hffff);
    chk_err("R10 back to status", 1, 3, 0);
    trap();
    chk_err("R10 back to int", 1, 2, 0);
    wr(0, 0, 16'hffff);
    chk_err("R10 none", 0, 0, 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_int_fp();
    t_partial();
    t_core();
    t_fatal();
    t_ilv();
    t_window();
    t_tt();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule